// File: doc/BRIEF.md
# DDR Write Recovery Timing Guard

This block sits in the command path of a DDR3-style memory controller and watches write bursts. For every WRITE it works out the clock edge that follows the final data beat on the bus. That edge is the write latency plus two clocks for a four-beat chopped burst, or plus four clocks for an eight-beat burst. From that reference edge it enforces two minimum gaps. The write-to-read gap applies to any READ to the device. The write recovery gap applies to a PRECHARGE aimed at the bank that was written.

The scheduler uses two kinds of flag: one read permission and one precharge permission per bank. The guard does not hold commands back. When a READ or PRECHARGE is issued while its permission is low, the guard raises a one-cycle violation pulse. Every other command passes through without affecting the flags. Latencies, burst mode and both gap lengths are configuration inputs, and the guard samples them on each WRITE.

Top module: `wr_recovery_guard`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the first cycle after it, `rd_ok` is 1, every bit of `pre_ok` is 1 and `viol` is 0.
- R2: Command codes on `cmd_code` are qualified by `cmd_valid`: 3'b001 is READ, 3'b010 is WRITE, 3'b011 is PRECHARGE. Bank index is `cmd_bank`.
- R3: In the cycle after a WRITE is accepted, `rd_ok` is 0.
- R4: `rd_ok` returns to 1 exactly WL + T + tWTR cycles after the WRITE edge. WL is `cfg_wl`, tWTR is `cfg_twtr`, and T is 2 when `cfg_burst_mode` is 2'b10 and 4 for any other value. A READ presented that many edges after the WRITE is legal.
- R5: The `pre_ok` bit of the written bank is 0 in the cycle after the WRITE. It returns to 1 exactly WL + T + tWR cycles after the WRITE edge, where tWR is `cfg_twr`.
- R6: A WRITE leaves the `pre_ok` bits of all other banks unchanged.
- R7: A further WRITE reloads a pending gap only if its new deadline is later than the remaining one. A gap never gets shorter.
- R8: WL, burst mode, tWTR and tWR are sampled on the WRITE edge. Later changes do not move a gap already running.
- R9: `viol` is 1 for exactly the one cycle after a READ presented while `rd_ok` is 0, or after a PRECHARGE presented while the addressed bank's `pre_ok` is 0.
- R10: Any other command code, including activate and refresh codes, and READ or PRECHARGE presented while permitted, leaves `viol` at 0 and does not change any flag.
- R11: With `cmd_valid` low, no code on `cmd_code` has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Command code (R2) |
| cmd_bank | input | BANK_W | Bank address of the command |
| cfg_wl | input | LAT_W | Write latency in clocks |
| cfg_burst_mode | input | 2 | 2'b10 selects four-beat chop, other values eight beats |
| cfg_twtr | input | CNT_W | Write-to-read gap in clocks |
| cfg_twr | input | CNT_W | Write recovery gap in clocks |
| rd_ok | output | 1 | A READ may be issued now |
| pre_ok | output | BANKS | Per bank: a PRECHARGE may be issued now |
| viol | output | 1 | One-cycle pulse after a blocked command was issued |

## Verification
Two things can happen in the same cycle. A new WRITE can arrive while an earlier gap is on its last count, and a READ or PRECHARGE can land exactly on the edge where its permission returns, or one edge before. The bench steps through each edge around the boundary after a WRITE. It also issues a second WRITE while the first gap is still running, once with a longer deadline and once with a shorter one. A behavioural model holds remaining-cycle integers per gap and is compared with the flags and the violation pulse on every clock. The model decides whether reload or expiry wins, and whether each command was legal, and no wait counts are hard-coded in the checks.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'b000,
        CMD_READ  = 3'b001,
        CMD_WRITE = 3'b010,
        CMD_PRE   = 3'b011,
        CMD_ACT   = 3'b100,
        CMD_REF   = 3'b101,
        CMD_MRS   = 3'b110,
        CMD_ZQ    = 3'b111
    } cmd_e;

    localparam logic [1:0] MODE_CHOP4 = 2'b10;

    typedef struct packed {
        logic wr;
        logic rd;
        logic pre;
    } cmd_kind_t;

    // Clocks from the first data beat to the edge after the last beat.
    function automatic logic [2:0] tail_clks(input logic [1:0] mode);
        return (mode == MODE_CHOP4) ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/wrg_decode.sv
module wrg_decode
    import wrg_pkg::*;
#(
    parameter int BANKS  = 8,
    parameter int BANK_W = 3,
    parameter int LAT_W  = 4,
    parameter int CNT_W  = 5,
    parameter int REM_W  = 6
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [LAT_W-1:0]  cfg_wl,
    input  logic [1:0]        cfg_burst_mode,
    input  logic [CNT_W-1:0]  cfg_twtr,
    input  logic [CNT_W-1:0]  cfg_twr,
    output cmd_kind_t         kind,
    output logic [BANKS-1:0]  bank_sel,
    output logic [REM_W-1:0]  rd_load,
    output logic [REM_W-1:0]  pre_load
);
    cmd_e             code;
    logic [REM_W-1:0] land;

    always_comb begin
        code     = cmd_e'(cmd_code);
        kind.wr  = cmd_valid && (code == CMD_WRITE);
        kind.rd  = cmd_valid && (code == CMD_READ);
        kind.pre = cmd_valid && (code == CMD_PRE);
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_sel
            assign bank_sel[b] = (cmd_bank == BANK_W'(b));
        end
    endgenerate

    assign land     = REM_W'(cfg_wl) + REM_W'(tail_clks(cfg_burst_mode));
    assign rd_load  = land + REM_W'(cfg_twtr);
    assign pre_load = land + REM_W'(cfg_twr);

endmodule

// File: rtl/wrg_countdown.sv
module wrg_countdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic         done
);
    logic [W-1:0] rem;
    logic [W-1:0] dec;

    assign dec  = (rem == '0) ? '0 : rem - W'(1);
    assign done = (rem == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (ld_en && (ld_val > dec)) begin
            rem <= ld_val;
        end else begin
            rem <= dec;
        end
    end

    // R5: a load of a non-zero gap blocks the permission next cycle
    p_load_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_val != '0) |=> !done);

    // R6: an expired gap stays expired unless loaded
    p_idle_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !ld_en) |=> done);

endmodule

// File: rtl/wr_recovery_guard.sv
module wr_recovery_guard
    import wrg_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int LAT_W = 4,
    parameter int CNT_W = 5,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int MAX_LD = (2 ** LAT_W - 1) + 4 + (2 ** CNT_W - 1),
    localparam int REM_W  = $clog2(MAX_LD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [LAT_W-1:0]  cfg_wl,
    input  logic [1:0]        cfg_burst_mode,
    input  logic [CNT_W-1:0]  cfg_twtr,
    input  logic [CNT_W-1:0]  cfg_twr,
    output logic              rd_ok,
    output logic [BANKS-1:0]  pre_ok,
    output logic              viol
);
    cmd_kind_t        kind;
    logic [BANKS-1:0] bank_sel;
    logic [REM_W-1:0] rd_load;
    logic [REM_W-1:0] pre_load;

    wrg_decode #(
        .BANKS(BANKS), .BANK_W(BANK_W), .LAT_W(LAT_W),
        .CNT_W(CNT_W), .REM_W(REM_W)
    ) u_dec (
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .cmd_bank      (cmd_bank),
        .cfg_wl        (cfg_wl),
        .cfg_burst_mode(cfg_burst_mode),
        .cfg_twtr      (cfg_twtr),
        .cfg_twr       (cfg_twr),
        .kind          (kind),
        .bank_sel      (bank_sel),
        .rd_load       (rd_load),
        .pre_load      (pre_load)
    );

    wrg_countdown #(.W(REM_W)) u_wtr (
        .clk   (clk),
        .rst   (rst),
        .ld_en (kind.wr),
        .ld_val(rd_load),
        .done  (rd_ok)
    );

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            wrg_countdown #(.W(REM_W)) u_wr (
                .clk   (clk),
                .rst   (rst),
                .ld_en (kind.wr && bank_sel[b]),
                .ld_val(pre_load),
                .done  (pre_ok[b])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            viol <= 1'b0;
        end else begin
            viol <= (kind.rd && !rd_ok) || (kind.pre && |(bank_sel & ~pre_ok));
        end
    end

    // R3: a WRITE blocks reads next cycle
    p_write_blocks_read_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_WRITE) |=> !rd_ok);

    // R9: an early READ is flagged
    p_early_read_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_READ && !rd_ok) |=> viol);

    // R10: a violation only follows a READ or PRECHARGE
    p_viol_source_r10: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(cmd_valid && (cmd_code == CMD_READ || cmd_code == CMD_PRE)));

    // R11: nothing valid, no violation next cycle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !viol);

endmodule

// File: tb/wr_recovery_guard_test.sv
module wr_recovery_guard_test;
    localparam int BANKS = 8;
    localparam int LAT_W = 4;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_code = 3'b000;
    logic [2:0]       cmd_bank = 3'd0;
    logic [LAT_W-1:0] cfg_wl = 4'd5;
    logic [1:0]       cfg_burst_mode = 2'b10;
    logic [CNT_W-1:0] cfg_twtr = 5'd4;
    logic [CNT_W-1:0] cfg_twr = 5'd6;
    logic             rd_ok;
    logic [BANKS-1:0] pre_ok;
    logic             viol;

    int    n_chk = 0;
    int    n_fail = 0;
    int    rd_rem = 0;
    int    pre_rem[BANKS];
    string req = "R1";

    always #10 clk = ~clk;

    wr_recovery_guard #(.BANKS(BANKS), .LAT_W(LAT_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cfg_wl(cfg_wl), .cfg_burst_mode(cfg_burst_mode),
        .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .rd_ok(rd_ok), .pre_ok(pre_ok),
        .viol(viol)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input bit ev);
        logic [BANKS-1:0] ep;
        for (int i = 0; i < BANKS; i++) ep[i] = (pre_rem[i] == 0);
        chk(rd_ok == (rd_rem == 0), "rd_ok", int'(rd_ok), int'(rd_rem == 0));
        chk(pre_ok == ep, "pre_ok", int'(pre_ok), int'(ep));
        chk(viol == ev, "viol", int'(viol), int'(ev));
    endtask

    // one clock: apply a command, advance the model, compare after the edge
    task automatic cyc(input bit v, input logic [2:0] c, input int b);
        bit ev;
        int land;
        cmd_valid = v;
        cmd_code  = c;
        cmd_bank  = b[2:0];
        ev = v && ((c == 3'b001 && rd_rem != 0) || (c == 3'b011 && pre_rem[b] != 0));
        land = int'(cfg_wl) + ((cfg_burst_mode == 2'b10) ? 2 : 4);
        if (rd_rem > 0) rd_rem--;
        for (int i = 0; i < BANKS; i++) if (pre_rem[i] > 0) pre_rem[i]--;
        if (v && c == 3'b010) begin
            if (land + int'(cfg_twtr) > rd_rem) rd_rem = land + int'(cfg_twtr);
            if (land + int'(cfg_twr) > pre_rem[b]) pre_rem[b] = land + int'(cfg_twr);
        end
        @(posedge clk);
        #5;
        compare(ev);
    endtask

    task automatic nop(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, 3'b000, 0);
    endtask

    initial begin
        for (int i = 0; i < BANKS; i++) pre_rem[i] = 0;
        // R1: reset state
        req = "R1";
        repeat (3) @(posedge clk);
        #5;
        compare(1'b0);
        rst = 1'b0;
        nop(1);

        // R2 R3 R4 R9: chopped burst, read boundary approached edge by edge
        req = "R4";
        cyc(1'b1, 3'b010, 2);
        nop(8);
        req = "R9";
        cyc(1'b1, 3'b001, 0);
        cyc(1'b1, 3'b001, 0);
        cyc(1'b1, 3'b001, 0);
        cyc(1'b1, 3'b001, 0);
        nop(4);

        // R5 R6: precharge to written bank and to another bank
        req = "R5";
        cyc(1'b1, 3'b010, 2);
        req = "R6";
        cyc(1'b1, 3'b011, 5);
        req = "R5";
        nop(10);
        cyc(1'b1, 3'b011, 2);
        cyc(1'b1, 3'b011, 2);
        cyc(1'b1, 3'b011, 2);
        cyc(1'b1, 3'b011, 2);
        nop(4);

        // R8: eight-beat burst, config changed in flight
        req = "R8";
        cfg_burst_mode = 2'b00;
        cyc(1'b1, 3'b010, 1);
        cfg_burst_mode = 2'b10;
        cfg_wl = 4'd9;
        cfg_twr = 5'd1;
        for (int k = 0; k < 16; k++) cyc(1'b1, 3'b011, 1);
        cfg_wl = 4'd5;
        cfg_twr = 5'd6;
        nop(6);

        // R7: second WRITE, first longer then shorter deadline
        req = "R7";
        cyc(1'b1, 3'b010, 3);
        nop(4);
        cfg_twtr = 5'd12;
        cyc(1'b1, 3'b010, 3);
        nop(3);
        cfg_twtr = 5'd0;
        cfg_twr = 5'd0;
        cyc(1'b1, 3'b010, 3);
        for (int k = 0; k < 22; k++) cyc(1'b1, (k % 2 == 0) ? 3'b001 : 3'b011, 3);
        cfg_twtr = 5'd4;
        cfg_twr = 5'd6;

        // R10: unrelated codes during a blocked window
        req = "R10";
        cyc(1'b1, 3'b010, 0);
        cyc(1'b1, 3'b100, 0);
        cyc(1'b1, 3'b101, 0);
        cyc(1'b1, 3'b110, 4);
        cyc(1'b1, 3'b111, 0);
        nop(16);
        cyc(1'b1, 3'b001, 0);
        cyc(1'b1, 3'b011, 0);

        // R11: invalid strobes carrying read, write and precharge codes
        req = "R11";
        cyc(1'b1, 3'b010, 6);
        cyc(1'b0, 3'b001, 6);
        cyc(1'b0, 3'b011, 6);
        cyc(1'b0, 3'b010, 7);
        nop(20);

        // R2: mixed traffic against the model
        req = "R2";
        for (int k = 0; k < 600; k++) begin
            if (k % 50 == 0) begin
                cfg_wl = 4'($urandom_range(5, 15));
                cfg_burst_mode = 2'($urandom_range(0, 3));
                cfg_twtr = 5'($urandom_range(0, 31));
                cfg_twr = 5'($urandom_range(0, 31));
            end
            cyc(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired in %s actual=running expected=done", req);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule